// File: doc/BRIEF.md
# Dual-Mode External Bus Strobe Generator

This block turns internal requests for external memory cycles into the control strobes of a 16-bit external bus. A request carries an address, a read/write flag and two byte-lane selects. The block runs each request as a timed cycle with three phases: setup, strobe and hold. A wait input can stretch the strobe phase.

A single mode bit in a 16-bit control register selects how the lane information reaches the pins. In write-strobe mode, the two shared byte pins act as separate high-byte and low-byte write strobes. The read strobe is common to both lanes, and a bus clock is driven out. In byte-enable mode, the same two pins carry high and low byte enables for the whole cycle, a common write strobe marks writes, and the bus clock is parked high. In byte-enable mode any wait timing is left to external logic.

The mode bit can only be set once an external cycle has completed since reset. A boot input forces write-strobe behaviour whatever the register holds. A mode change never alters a cycle that is already running.

Top module: `ebus_strobe_gen`

## Requirements
- R1: After reset the control register reads 0x0000, all four strobes are high, `busy_o` is 0 and the bus runs in write-strobe mode.
- R2: The register answers only at address `MODE_ADDR`. Its bit 15 is the mode bit (0 = write-strobe mode, 1 = byte-enable mode). Bits 0 to 14 read as zero and ignore writes. Reads at any other address return zero.
- R3: A write of 1 to the mode bit is ignored until at least one external cycle has completed since reset. After that, the bit is writable.
- R4: In write-strobe mode, a write drives `bus_strb_hi_n_o` low for lane 1 (`req_be_i[1]`, high byte) and `bus_strb_lo_n_o` low for lane 0 (`req_be_i[0]`), only during the strobe phase. `bus_wr_n_o` stays high.
- R5: In write-strobe mode, a read drives `bus_rd_n_o` low during the strobe phase and leaves both byte strobes high.
- R6: In write-strobe mode, each clock edge at the end of the strobe phase that samples `bus_wait_n_i` low extends the strobe phase by one clock.
- R7: In byte-enable mode, the byte pins are low for the selected lanes through setup, strobe and hold, on both reads and writes. `bus_wr_n_o` (writes) or `bus_rd_n_o` (reads) is low during the strobe phase only.
- R8: In byte-enable mode, `bus_clk_o` is held high and `bus_wait_n_i` has no effect on cycle length.
- R9: In write-strobe mode, `bus_clk_o` toggles on every clock, both idle and during cycles.
- R10: While `boot_mode_i` is high, the block behaves as in write-strobe mode, and the register keeps and reads back its stored value.
- R11: The mode is sampled when a cycle starts. A register write during a cycle takes effect from the next cycle.
- R12: A cycle lasts `SETUP_CYC + STROBE_CYC + HOLD_CYC` clocks plus any wait extension. `cyc_done_o` pulses in its last clock, and all strobes are high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_mode_i | input | 1 | Forces write-strobe behaviour |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | REG_AW | Register address |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data |
| req_valid_i | input | 1 | Start a cycle (taken when idle) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Cycle address |
| req_be_i | input | 2 | Lane selects, bit 1 high byte |
| bus_wait_n_i | input | 1 | Active-low wait |
| bus_addr_o | output | ADDR_W | Latched cycle address |
| busy_o | output | 1 | Cycle in progress |
| cyc_done_o | output | 1 | Last clock of a cycle |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_strb_hi_n_o | output | 1 | High write strobe or high byte enable |
| bus_strb_lo_n_o | output | 1 | Low write strobe or low byte enable |
| bus_wr_n_o | output | 1 | Common write strobe (byte-enable mode) |
| bus_clk_o | output | 1 | Bus clock output |

## Verification
The bound assertions check on every clock that idle strobes are high, that reserved register bits read zero, and that the mode bit stays clear until a cycle has completed. They also check that the read and write strobes are never low together, that write-strobe cycles leave the common write strobe high, and that byte-enable cycles keep the bus clock parked. The bench scenarios cover what needs a whole cycle to show: per-lane strobe lengths in both modes, wait extension and its absence in byte-enable mode, the boot override, and a mode write landing in the middle of a cycle.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic mode;   // 1 = byte-enable scheme
        logic seen;   // an external cycle has completed since reset
    } modereg_t;

endpackage

// File: rtl/ebs_mode_reg.sv
module ebs_mode_reg
    import ebs_pkg::*;
#(
    parameter int REG_AW    = 4,
    parameter int REG_W     = 16,
    parameter int MODE_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic              wbit_i,
    input  logic              ext_done_i,
    output logic              mode_o,
    output logic [REG_W-1:0]  rdata_o
);
    localparam int MODE_BIT = REG_W - 1;

    modereg_t r_d, r_q;
    logic     hit;

    assign hit = (addr_i == REG_AW'(MODE_ADDR));

    always_comb begin
        r_d = r_q;
        if (ext_done_i) begin
            r_d.seen = 1'b1;
        end
        if (we_i && hit) begin
            // setting is locked out until a cycle has finished
            r_d.mode = wbit_i & r_q.seen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit) begin
            rdata_o[MODE_BIT] = r_q.mode;
        end
    end

    assign mode_o = r_q.mode;

endmodule

// File: rtl/ebs_cycle_fsm.sv
module ebs_cycle_fsm
    import ebs_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_be_i,
    input  logic              mode_eff_i,
    input  logic              wait_n_i,
    output phase_e            phase_o,
    output logic              write_o,
    output logic [1:0]        be_o,
    output logic              mode_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int MAX_C  = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
    localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic              write;
        logic [1:0]        be;
        logic              mode;
        logic [ADDR_W-1:0] addr;
    } cyc_t;

    cyc_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.phase)
            PH_IDLE: begin
                if (req_valid_i) begin
                    c_d.phase = PH_SETUP;
                    c_d.cnt   = CNT_W'(SETUP_CYC - 1);
                    c_d.write = req_write_i;
                    c_d.be    = req_be_i;
                    c_d.mode  = mode_eff_i;
                    c_d.addr  = req_addr_i;
                end
            end
            PH_SETUP: begin
                if (c_q.cnt == '0) begin
                    c_d.phase = PH_STROBE;
                    c_d.cnt   = CNT_W'(STROBE_CYC - 1);
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else if (!c_q.mode && !wait_n_i) begin
                    c_d.phase = PH_STROBE;   // stretched by one clock
                end else begin
                    c_d.phase = PH_HOLD;
                    c_d.cnt   = CNT_W'(HOLD_CYC - 1);
                end
            end
            PH_HOLD: begin
                if (c_q.cnt == '0) begin
                    c_d.phase = PH_IDLE;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign phase_o = c_q.phase;
    assign write_o = c_q.write;
    assign be_o    = c_q.be;
    assign mode_o  = c_q.mode;
    assign addr_o  = c_q.addr;
    assign done_o  = (c_q.phase == PH_HOLD) && (c_q.cnt == '0);

endmodule

// File: rtl/ebs_pin_mux.sv
module ebs_pin_mux
    import ebs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_e     phase_i,
    input  logic       write_i,
    input  logic [1:0] be_i,
    input  logic       cyc_mode_i,
    input  logic       mode_eff_i,
    output logic       rd_n_o,
    output logic       strb_hi_n_o,
    output logic       strb_lo_n_o,
    output logic       wr_n_o,
    output logic       bclk_o
);
    logic busy, in_strobe, use_be;
    logic bclk_d, bclk_q;

    assign busy      = (phase_i != PH_IDLE);
    assign in_strobe = (phase_i == PH_STROBE);
    assign use_be    = busy ? cyc_mode_i : mode_eff_i;

    always_comb begin
        rd_n_o      = 1'b1;
        strb_hi_n_o = 1'b1;
        strb_lo_n_o = 1'b1;
        wr_n_o      = 1'b1;
        if (in_strobe && !write_i) begin
            rd_n_o = 1'b0;
        end
        if (!cyc_mode_i) begin
            if (in_strobe && write_i) begin
                strb_hi_n_o = ~be_i[1];
                strb_lo_n_o = ~be_i[0];
            end
        end else if (busy) begin
            strb_hi_n_o = ~be_i[1];
            strb_lo_n_o = ~be_i[0];
            if (in_strobe && write_i) begin
                wr_n_o = 1'b0;
            end
        end
    end

    always_comb begin
        bclk_d = use_be ? 1'b1 : ~bclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b1;
        end else begin
            bclk_q <= bclk_d;
        end
    end

    assign bclk_o = bclk_q;

endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
    import ebs_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int REG_AW     = 4,
    parameter int REG_W      = 16,
    parameter int MODE_ADDR  = 3,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode_i,
    input  logic              reg_we_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_be_i,
    input  logic              bus_wait_n_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              busy_o,
    output logic              cyc_done_o,
    output logic              bus_rd_n_o,
    output logic              bus_strb_hi_n_o,
    output logic              bus_strb_lo_n_o,
    output logic              bus_wr_n_o,
    output logic              bus_clk_o
);
    localparam int MODE_BIT = REG_W - 1;

    logic       mode_q, mode_eff, cyc_mode, cyc_write, done;
    logic [1:0] cyc_be;
    phase_e     phase;
    logic       unused_wdata;

    assign unused_wdata = ^reg_wdata_i[MODE_BIT-1:0];
    assign mode_eff     = mode_q & ~boot_mode_i;

    ebs_mode_reg #(
        .REG_AW   (REG_AW),
        .REG_W    (REG_W),
        .MODE_ADDR(MODE_ADDR)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wbit_i    (reg_wdata_i[MODE_BIT]),
        .ext_done_i(done),
        .mode_o    (mode_q),
        .rdata_o   (reg_rdata_o)
    );

    ebs_cycle_fsm #(
        .ADDR_W    (ADDR_W),
        .SETUP_CYC (SETUP_CYC),
        .STROBE_CYC(STROBE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid_i(req_valid_i),
        .req_write_i(req_write_i),
        .req_addr_i (req_addr_i),
        .req_be_i   (req_be_i),
        .mode_eff_i (mode_eff),
        .wait_n_i   (bus_wait_n_i),
        .phase_o    (phase),
        .write_o    (cyc_write),
        .be_o       (cyc_be),
        .mode_o     (cyc_mode),
        .addr_o     (bus_addr_o),
        .done_o     (done)
    );

    ebs_pin_mux u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .write_i    (cyc_write),
        .be_i       (cyc_be),
        .cyc_mode_i (cyc_mode),
        .mode_eff_i (mode_eff),
        .rd_n_o     (bus_rd_n_o),
        .strb_hi_n_o(bus_strb_hi_n_o),
        .strb_lo_n_o(bus_strb_lo_n_o),
        .wr_n_o     (bus_wr_n_o),
        .bclk_o     (bus_clk_o)
    );

    assign busy_o     = (phase != PH_IDLE);
    assign cyc_done_o = done;

endmodule

// File: rtl/ebs_checks.sv
module ebs_checks #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             rd_n,
    input logic             hi_n,
    input logic             lo_n,
    input logic             wr_n,
    input logic             bclk,
    input logic [REG_W-1:0] rdata,
    input logic             cyc_mode,
    input logic             mode_q
);
    logic seen_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_done <= 1'b0;
        end else if (done) begin
            seen_done <= 1'b1;
        end
    end

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && hi_n && lo_n && wr_n));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[REG_W-2:0] == '0);

    assert_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_done |-> !mode_q);

    assert_no_common_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cyc_mode) |-> wr_n);

    assert_rd_wr_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_bclk_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cyc_mode && $past(busy && cyc_mode)) |-> bclk);

endmodule

bind ebus_strobe_gen ebs_checks #(.REG_W(REG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_o),
    .done    (cyc_done_o),
    .rd_n    (bus_rd_n_o),
    .hi_n    (bus_strb_hi_n_o),
    .lo_n    (bus_strb_lo_n_o),
    .wr_n    (bus_wr_n_o),
    .bclk    (bus_clk_o),
    .rdata   (reg_rdata_o),
    .cyc_mode(cyc_mode),
    .mode_q  (mode_q)
);

// File: tb/ebus_strobe_gen_test.sv
`timescale 1ns/1ps
module ebus_strobe_gen_test;
    localparam int ADDR_W = 20;
    localparam int REG_AW = 4;
    localparam int REG_W  = 16;
    localparam int MADDR  = 3;
    localparam int ST     = 2;
    localparam int BASE   = 4;   // setup + strobe + hold

    logic clk = 1'b0, rst_n = 1'b0, boot = 1'b0;
    logic reg_we = 1'b0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [REG_W-1:0]  reg_wdata = '0, reg_rdata;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0, bus_addr;
    logic [1:0] req_be = '0;
    logic wait_n = 1'b1;
    logic busy, done, rd_n, hi_n, lo_n, wr_n, bclk;

    int checks = 0, errors = 0;
    int wait_req = 0;
    bit force_wait_low = 1'b0;
    int scnt = 0;

    typedef struct {
        int rd; int hi; int lo; int wr; int len; string req;
    } exp_t;
    exp_t expq[$];
    int a_rd = 0, a_hi = 0, a_lo = 0, a_wr = 0, a_len = 0;

    always #2.5 clk = ~clk;

    ebus_strobe_gen #(
        .ADDR_W(ADDR_W), .REG_AW(REG_AW), .REG_W(REG_W), .MODE_ADDR(MADDR),
        .SETUP_CYC(1), .STROBE_CYC(ST), .HOLD_CYC(1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .boot_mode_i(boot),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
        .req_be_i(req_be), .bus_wait_n_i(wait_n), .bus_addr_o(bus_addr),
        .busy_o(busy), .cyc_done_o(done), .bus_rd_n_o(rd_n),
        .bus_strb_hi_n_o(hi_n), .bus_strb_lo_n_o(lo_n), .bus_wr_n_o(wr_n),
        .bus_clk_o(bclk)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: accumulate strobe-low clocks per cycle, compare at cycle end
    always @(negedge clk) begin
        if (rst_n && busy) begin
            a_len++;
            if (!rd_n) a_rd++;
            if (!hi_n) a_hi++;
            if (!lo_n) a_lo++;
            if (!wr_n) a_wr++;
            if (done) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R12", "unexpected cycle", a_len, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(a_rd == e.rd, e.req, "rd low clocks", a_rd, e.rd);
                    check(a_hi == e.hi, e.req, "hi strobe low clocks", a_hi, e.hi);
                    check(a_lo == e.lo, e.req, "lo strobe low clocks", a_lo, e.lo);
                    check(a_wr == e.wr, e.req, "wr low clocks", a_wr, e.wr);
                    check(a_len == e.len, "R12", "cycle length", a_len, e.len);
                end
                a_rd = 0; a_hi = 0; a_lo = 0; a_wr = 0; a_len = 0;
            end
        end
    end

    // wait generator: hold wait low for wait_req clocks past the nominal strobe end
    always @(negedge clk) begin
        if (force_wait_low) begin
            wait_n = 1'b0;
        end else if (busy && (!rd_n || !hi_n || !lo_n)) begin
            wait_n = (scnt >= ST - 1 + wait_req);
            scnt++;
        end else begin
            scnt = 0;
            wait_n = 1'b1;
        end
    end

    task automatic reg_write(input int addr, input int data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = REG_AW'(addr); reg_wdata = REG_W'(data);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input int addr, output int data);
        @(negedge clk);
        reg_addr = REG_AW'(addr);
        #1;
        data = int'(reg_rdata);
    endtask

    task automatic bus_start(input bit wr, input logic [1:0] be,
                             input int erd, input int ehi, input int elo,
                             input int ewr, input int elen, input string req);
        exp_t e;
        e.rd = erd; e.hi = ehi; e.lo = elo; e.wr = ewr; e.len = elen; e.req = req;
        expq.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_be = be; req_addr = 20'h1A5;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic bus_cycle(input bit wr, input logic [1:0] be,
                             input int erd, input int ehi, input int elo,
                             input int ewr, input int elen, input string req);
        bus_start(wr, be, erd, ehi, elo, ewr, elen, req);
        wait_idle();
    endtask

    task automatic bclk_toggles(input string req, input bit expect_toggle);
        logic b0;
        @(negedge clk); b0 = bclk;
        @(negedge clk);
        if (expect_toggle)
            check(bclk != b0, req, "bclk toggles", int'(bclk), int'(!b0));
        else
            check(bclk == 1'b1 && b0 == 1'b1, req, "bclk parked high", int'(bclk), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rv;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({rd_n, hi_n, lo_n, wr_n} == 4'hF, "R1", "strobes after reset",
              int'({rd_n, hi_n, lo_n, wr_n}), 15);
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        rst_n = 1'b1;
        reg_read(MADDR, rv);
        check(rv == 0, "R1", "register after reset", rv, 0);
        bclk_toggles("R9", 1'b1);
        check({rd_n, hi_n, lo_n, wr_n} == 4'hF, "R12", "idle strobes",
              int'({rd_n, hi_n, lo_n, wr_n}), 15);

        // R3 lockout before any external cycle
        reg_write(MADDR, 16'h8000);
        reg_read(MADDR, rv);
        check(rv == 0, "R3", "mode write before first cycle", rv, 0);

        // write-strobe mode cycles
        bus_cycle(1'b1, 2'b10, 0, ST, 0, 0, BASE, "R4");
        bus_cycle(1'b1, 2'b01, 0, 0, ST, 0, BASE, "R4");
        bus_cycle(1'b0, 2'b11, ST, 0, 0, 0, BASE, "R5");
        wait_req = 3;
        bus_cycle(1'b1, 2'b11, 0, ST + 3, ST + 3, 0, BASE + 3, "R6");
        wait_req = 1;
        bus_cycle(1'b0, 2'b01, ST + 1, 0, 0, 0, BASE + 1, "R6");
        wait_req = 0;

        // R2 / R3 register behaviour after a cycle
        reg_write(MADDR, 16'hFFFF);
        reg_read(MADDR, rv);
        check(rv == 16'h8000, "R2", "reserved bits ignore writes", rv, 16'h8000);
        check(rv[15] == 1'b1, "R3", "mode settable after cycle", rv, 16'h8000);
        reg_read(MADDR + 1, rv);
        check(rv == 0, "R2", "other address reads zero", rv, 0);

        // byte-enable mode
        bclk_toggles("R8", 1'b0);
        bus_cycle(1'b1, 2'b01, 0, 0, BASE, ST, BASE, "R7");
        bus_cycle(1'b0, 2'b10, ST, BASE, 0, 0, BASE, "R7");
        force_wait_low = 1'b1;
        bus_cycle(1'b1, 2'b11, 0, BASE, BASE, ST, BASE, "R8");
        force_wait_low = 1'b0;

        // boot override
        boot = 1'b1;
        reg_read(MADDR, rv);
        check(rv == 16'h8000, "R10", "register kept under boot", rv, 16'h8000);
        bclk_toggles("R10", 1'b1);
        bus_cycle(1'b1, 2'b10, 0, ST, 0, 0, BASE, "R10");
        boot = 1'b0;
        bclk_toggles("R8", 1'b0);

        // R11 mode write mid-cycle
        bus_start(1'b1, 2'b11, 0, BASE, BASE, ST, BASE, "R11");
        check(busy == 1'b1, "R11", "cycle running during write", int'(busy), 1);
        reg_write(MADDR, 16'h0000);
        wait_idle();
        bus_cycle(1'b1, 2'b11, 0, ST, ST, 0, BASE, "R11");

        check(expq.size() == 0, "R12", "all cycles observed", expq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule